// File: doc/BRIEF.md
# Power-Fail Write-Protect and Backup Sequencer

This block sits between a host and a battery-backed static memory. It decides, from the state of the supply, when host accesses may reach the memory. It takes three digitized supply-monitor flags and the host's active-low chip, write and output enables. From these it produces gated memory strobes, a data-drive enable for the memory's output buffers, a select between main and battery supply, and a battery-connect enable. The analog comparators, the battery and the memory array sit outside the block. The comparators arrive as the three flags, and the outputs drive the array and the power switch.

Each supply flag passes through a two-flop synchronizer and a consecutive-cycle hysteresis filter. A five-state machine then acts on the filtered flags. SEALED is the reset state. In it the battery stays isolated until the supply first reaches the first-power level. PROTECTED blocks all access. BATTERY moves the memory onto the battery. RECOVER holds access off after power returns. NORMAL passes the host strobes through. The recovery hold is a parameterised cycle count, and the host must keep chip enable inactive for the whole of it.

Top module: `nvg_guard`

## Requirements
- R1: After reset, all memory strobes are high (inactive), the data-drive enable is 0, the battery select is 0 and the battery-connect enable is 0.
- R2: While the first-power flag has never been seen high, the battery-connect enable and the battery select stay 0 and access stays blocked. This holds even when the switchover flag is low.
- R3: Once the filtered first-power flag is high, the battery-connect enable goes to 1. It never returns to 0 until the next reset.
- R4: In normal operation each memory strobe equals the matching host strobe. The data-drive enable is 1 exactly when chip enable and output enable are low and write enable is high.
- R5: When the filtered write-protect flag is low, all memory strobes are forced high and the data-drive enable is 0 for any host input. A write in progress is cut off in the same cycle the filtered flag falls.
- R6: After arming, a low filtered switchover flag sets the battery select to 1. A high filtered switchover flag returns it to 0.
- R7: After the write-protect flag returns high, access stays blocked until REC_CYCLES consecutive cycles pass with host chip enable high. Any cycle with chip enable low restarts that count.
- R8: A supply flag level that lasts fewer than HYST cycles after the synchronizer does not change the filtered flag. A level that lasts HYST cycles does. Total flag latency is 2 + HYST cycles.
- R9: If the write-protect flag drops during the recovery hold, access goes back to blocked. The full recovery count starts again once the flag returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_wp_ok | input | 1 | Supply above write-protect threshold |
| sup_sw_ok | input | 1 | Supply above battery switchover level |
| sup_fresh_ok | input | 1 | Supply above first-power (seal release) level |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to memory |
| mem_we_n | output | 1 | Gated write enable to memory |
| mem_oe_n | output | 1 | Gated output enable to memory |
| dq_drive | output | 1 | Memory data output buffer enable |
| pwr_sel_batt | output | 1 | 1 selects battery as memory supply |
| batt_connect | output | 1 | Battery connected for backup |

## Verification
The bench cuts a write off in mid-cycle by dropping the protect flag while write enable is held low. A design that lets the write finish would show the memory write strobe still low several cycles later. It probes chip enable partway through the recovery hold and then waits less than a full count. A design that does not restart the count, or that keeps counting across a supply dip during recovery, would open access too early. It drops the switchover flag while still sealed, where a wrong design would connect the battery. It sends two-cycle flag glitches, which a missing filter would turn into blocked accesses in the middle of normal traffic.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
  typedef enum logic [2:0] {
    ST_SEALED = 3'd0,
    ST_NORMAL = 3'd1,
    ST_PROT   = 3'd2,
    ST_BATT   = 3'd3,
    ST_RECOV  = 3'd4
  } pwr_state_e;

  localparam int NFLAG     = 3;
  localparam int FLG_WP    = 0;
  localparam int FLG_SW    = 1;
  localparam int FLG_FRESH = 2;
endpackage

// File: rtl/nvg_flag_filter.sv
module nvg_flag_filter #(
  parameter int HYST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (HYST > 1) ? $clog2(HYST) : 1;

  logic          sync_q1, sync_q2;
  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mism;

  always_comb begin
    mism   = sync_q2 ^ filt_q;
    filt_d = filt_q;
    cnt_d  = '0;
    if (mism) begin
      if (cnt_q == CW'(HYST-1)) begin
        filt_d = sync_q2;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
      filt_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync_q1 <= raw_i;
      sync_q2 <= sync_q1;
      filt_q  <= filt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign filt_o = filt_q;

  // R8
  hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(cnt_q) == CW'(HYST-1)));
endmodule

// File: rtl/nvg_seq_fsm.sv
module nvg_seq_fsm
  import nvg_pkg::*;
#(
  parameter int REC_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_ok,
  input  logic sw_ok,
  input  logic fresh_ok,
  input  logic host_ce_n,
  output logic access_en,
  output logic sel_batt,
  output logic batt_en
);
  localparam int CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;

  pwr_state_e    st_q, st_d;
  logic [CW-1:0] rc_q, rc_d;
  logic          rc_en;
  logic          rc_done;

  assign rc_done = host_ce_n && (rc_q == CW'(REC_CYCLES-1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SEALED: if (fresh_ok) st_d = ST_PROT;
      ST_PROT: begin
        if (!sw_ok)      st_d = ST_BATT;
        else if (wp_ok)  st_d = ST_RECOV;
      end
      ST_BATT:   if (sw_ok) st_d = ST_PROT;
      ST_RECOV: begin
        if (!wp_ok)       st_d = ST_PROT;
        else if (rc_done) st_d = ST_NORMAL;
      end
      ST_NORMAL: if (!wp_ok) st_d = ST_PROT;
      default:   st_d = ST_SEALED;
    endcase
  end

  always_comb begin
    rc_en = (st_q == ST_RECOV) || (rc_q != '0);
    if ((st_q == ST_RECOV) && wp_ok && host_ce_n && !rc_done)
      rc_d = rc_q + CW'(1);
    else
      rc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_SEALED;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rc_q <= '0;
    else if (rc_en) rc_q <= rc_d;
  end

  assign access_en = (st_q == ST_NORMAL);
  assign sel_batt  = (st_q == ST_BATT);
  assign batt_en   = (st_q != ST_SEALED);

  // R3
  batt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(batt_en));

  // R6
  sel_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_batt |-> batt_en);

  // R7
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_NORMAL) && ($past(st_q) != ST_NORMAL)) |->
      (($past(st_q) == ST_RECOV) && $past(host_ce_n)));
endmodule

// File: rtl/nvg_strobe_gate.sv
module nvg_strobe_gate (
  input  logic access_en,
  input  logic wp_ok,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic dq_drive
);
  logic open_w;

  always_comb begin
    open_w   = access_en & wp_ok;
    mem_ce_n = host_ce_n | ~open_w;
    mem_we_n = host_we_n | ~open_w;
    mem_oe_n = host_oe_n | ~open_w;
    dq_drive = open_w & ~host_ce_n & ~host_oe_n & host_we_n;
  end
endmodule

// File: rtl/nvg_guard.sv
module nvg_guard
  import nvg_pkg::*;
#(
  parameter int HYST       = 4,
  parameter int REC_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_wp_ok,
  input  logic sup_sw_ok,
  input  logic sup_fresh_ok,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic dq_drive,
  output logic pwr_sel_batt,
  output logic batt_connect
);
  logic [NFLAG-1:0] flag_raw;
  logic [NFLAG-1:0] flag_f;
  logic             access_en;

  assign flag_raw[FLG_WP]    = sup_wp_ok;
  assign flag_raw[FLG_SW]    = sup_sw_ok;
  assign flag_raw[FLG_FRESH] = sup_fresh_ok;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flt
    nvg_flag_filter #(.HYST(HYST)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (flag_raw[g]),
      .filt_o (flag_f[g])
    );
  end

  nvg_seq_fsm #(.REC_CYCLES(REC_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_ok     (flag_f[FLG_WP]),
    .sw_ok     (flag_f[FLG_SW]),
    .fresh_ok  (flag_f[FLG_FRESH]),
    .host_ce_n (host_ce_n),
    .access_en (access_en),
    .sel_batt  (pwr_sel_batt),
    .batt_en   (batt_connect)
  );

  nvg_strobe_gate u_gate (
    .access_en (access_en),
    .wp_ok     (flag_f[FLG_WP]),
    .host_ce_n (host_ce_n),
    .host_we_n (host_we_n),
    .host_oe_n (host_oe_n),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .dq_drive  (dq_drive)
  );

  // R5
  protect_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_f[FLG_WP] |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_drive));
endmodule

// File: tb/nvg_guard_tb.sv
module nvg_guard_tb;
  localparam int HYST = 4;
  localparam int REC  = 20;
  localparam int LAT  = 2 + HYST;

  logic clk = 1'b0;
  logic rst_n;
  logic wp, sw, fr;
  logic ce_n, we_n, oe_n;
  logic m_ce_n, m_we_n, m_oe_n, dq, sel_b, batt;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  nvg_guard #(.HYST(HYST), .REC_CYCLES(REC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .sup_wp_ok(wp), .sup_sw_ok(sw), .sup_fresh_ok(fr),
    .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n),
    .mem_ce_n(m_ce_n), .mem_we_n(m_we_n), .mem_oe_n(m_oe_n),
    .dq_drive(dq), .pwr_sel_batt(sel_b), .batt_connect(batt)
  );

  function automatic logic [3:0] exp_gate(input logic open,
      input logic c, input logic w, input logic o);
    if (!open) return 4'b1110;
    return {c, w, o, (~c & ~o & w)};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host(input logic c, input logic w, input logic o);
    ce_n = c; we_n = w; oe_n = o;
  endtask

  function automatic logic [3:0] gate_now();
    return {m_ce_n, m_we_n, m_oe_n, dq};
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wp = 0; sw = 0; fr = 0;
    host(1, 1, 1);
    step(3);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 strobes", gate_now(), 4'b1110);
    chk("R1 power", {2'b00, sel_b, batt}, 4'b0000);

    // R2 sealed: switchover low, host active, battery isolated
    step(1); host(0, 1, 0);
    step(LAT + 4); #2;
    chk("R2 sealed power", {2'b00, sel_b, batt}, 4'b0000);
    chk("R2 sealed blocked", gate_now(), 4'b1110);

    // power up, host keeps chip enable low
    step(1); sw = 1; fr = 1;
    step(LAT + 4); #2;
    chk("R3 armed", {3'b000, batt}, 4'b0001);
    step(1); wp = 1;
    step(LAT + 6); #2;
    chk("R7 held by ce low", gate_now(), 4'b1110);

    // R7 recovery count with restart
    step(1); host(1, 1, 1);
    step(REC / 2);
    host(0, 1, 0); #2;
    chk("R7 early probe", gate_now(), 4'b1110);
    step(1); host(1, 1, 1);
    step(REC / 2 + 2);
    host(0, 1, 0); #2;
    chk("R7 restart probe", gate_now(), 4'b1110);
    step(1); host(1, 1, 1);
    step(REC + 3);
    host(0, 1, 0); #2;
    chk("R7 open after hold", gate_now(), 4'b0101);

    // R4 random traffic in normal operation
    for (int i = 0; i < 200; i++) begin
      logic c, w, o;
      step(1);
      c = 1'($urandom); w = 1'($urandom); o = 1'($urandom);
      host(c, w, o); #2;
      chk("R4 pass-through", gate_now(), exp_gate(1'b1, c, w, o));
    end
    chk("R3 still armed", {2'b00, sel_b, batt}, 4'b0001);

    // R8 short glitches on the protect and switchover flags
    step(1); host(0, 0, 1);
    wp = 0; sw = 0;
    step(2); wp = 1; sw = 1;
    for (int i = 0; i < LAT + 4; i++) begin
      step(1); #2;
      chk("R8 glitch ignored", gate_now(), 4'b0010);
      chk("R8 no switchover", {2'b00, sel_b, batt}, 4'b0001);
    end

    // R5 write in progress is cut off
    step(1); wp = 0;
    begin
      int cut_at = -1;
      for (int i = 0; i < LAT + 4; i++) begin
        step(1); #2;
        if (m_we_n && cut_at < 0) cut_at = i;
      end
      chk("R5 write cut", {3'b000, (cut_at >= 0 && cut_at <= LAT)}, 4'b0001);
    end
    for (int i = 0; i < 60; i++) begin
      logic c, w, o;
      step(1);
      c = 1'($urandom); w = 1'($urandom); o = 1'($urandom);
      host(c, w, o); #2;
      chk("R5 protected ignore", gate_now(), 4'b1110);
    end

    // R6 battery switchover
    step(1); sw = 0;
    step(LAT + 3); #2;
    chk("R6 on battery", {2'b00, sel_b, batt}, 4'b0011);
    chk("R5 blocked on battery", gate_now(), 4'b1110);
    step(1); sw = 1;
    step(LAT + 3); #2;
    chk("R6 back to main", {2'b00, sel_b, batt}, 4'b0001);

    // R9 dip during recovery restarts the count
    step(1); host(1, 1, 1); wp = 1;
    step(LAT + 10);
    wp = 0;
    step(LAT + 6); #2;
    chk("R9 dip blocks", gate_now(), 4'b1110);
    wp = 1;
    step(LAT + 12);
    host(0, 1, 0); #2;
    chk("R9 count restarted", gate_now(), 4'b1110);
    step(1); host(1, 1, 1);
    step(REC + 3);
    host(0, 1, 0); #2;
    chk("R9 open after full hold", gate_now(), 4'b0101);
    for (int i = 0; i < 40; i++) begin
      logic c, w, o;
      step(1);
      c = 1'($urandom); w = 1'($urandom); o = 1'($urandom);
      host(c, w, o); #2;
      chk("R4 pass-through again", gate_now(), exp_gate(1'b1, c, w, o));
    end

    // R1 second reset returns to sealed
    step(1); rst_n = 0; #2;
    chk("R1 reset again", {2'b00, sel_b, batt}, 4'b0000);
    step(1); rst_n = 1;
    step(2);
    finish_run();
  end
endmodule